// File: doc/BRIEF.md
# DRAM Read Command Issuer

This block sits on the controller side of a graphics-class x32 DRAM and turns queued read requests into READ commands on the command and address pins. A request carries a bank, a 9-bit starting column and an auto-precharge flag. Requests pass through a small in-order queue. A three-state machine then launches one READ per request. Back-to-back READs are spaced by exactly one burst duration, so the data bursts join with no gap and none is ever cut short.

CAS latency and burst length (4 or 8 elements, which is 2 or 4 clocks under 4n prefetch) are captured while reset is held. The block predicts the clocks on which read data will appear and drives a data-valid strobe that follows those clocks exactly. For reads with auto precharge it watches per-bank activation pulses. It holds such a read until the row has been open long enough that the close at the end of the burst respects tRAS(min).

States: `ST_READY` means no spacing is pending and the head request may launch. `ST_GAP` means a READ was just launched and the burst-spacing counter is running. `ST_RAS_WAIT` means the head request has auto precharge and its bank's row is not yet old enough.

Transitions:
- `ST_READY` to `ST_GAP` on launch.
- `ST_READY` to `ST_RAS_WAIT` when the head is held by the row-age rule.
- `ST_RAS_WAIT` to `ST_GAP` on launch once the row is old enough.
- `ST_GAP` to `ST_READY` when the spacing counter reaches its last clock.

Top module: `gddr_rd_issuer`

## Requirements
- R1: A launched READ is shown on the pins for exactly one clock as cs_n=0, ras_n=1, cas_n=0, we_n=1. On every other clock the pins show deselect: cs_n=1, ras_n=1, cas_n=1, we_n=1, with addr and ba zero.
- R2: During a READ, ba carries the bank and addr[8] carries the auto-precharge flag. addr[7:0] carries column bits 7..0 and addr[9] carries column bit 8. addr[11:10] are driven 0.
- R3: A request accepted on clock k (req_valid and req_ready high) is launched no earlier than clock k+2. Requests are launched in acceptance order, and each is launched at the first clock that the spacing rule (R5) and the row-age rule (R7) allow.
- R4: For a READ on the pins at clock t, rd_valid is high on clocks t+CL through t+CL+BL/2-1, where CL is the latched CAS latency and BL is the latched burst length. It is low on every clock not covered by some READ.
- R5: Two READs are never closer than BL/2 clocks. Requests that are queued back to back launch exactly BL/2 clocks apart, so rd_valid stays high without a gap across their bursts.
- R6: A later READ never shortens an earlier burst: every READ yields its full BL/2 clocks of rd_valid.
- R7: A READ with auto precharge to a bank whose activation pulse came on clock a is not launched before clock a+TRAS_MIN-BL/2. A READ without auto precharge is not delayed by this rule.
- R8: cfg_cas_lat (1..CL_MAX) and cfg_bl8 (1 selects BL=8, 0 selects BL=4) are captured while rst_n is low. Changing them while rst_n is high does not affect command spacing or rd_valid timing.
- R9: req_ready falls when FIFO_DEPTH requests are waiting. No accepted request is lost or launched twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg_cas_lat | input | 4 | CAS latency in clocks, 1..CL_MAX |
| cfg_bl8 | input | 1 | Burst length select: 1 = 8 elements, 0 = 4 elements |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Queue can accept a request |
| req_bank | input | 2 | Request bank |
| req_col | input | 9 | Request starting column |
| req_ap | input | 1 | Request auto-precharge flag |
| act_bank_stb | input | 4 | One pulse per bank when its row is activated |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 12 | Address pins |
| ba | output | 2 | Bank address pins |
| rd_valid | output | 1 | Predicted read-data-valid strobe |

## Verification
Requests queued with no idle clocks show whether READs land exactly one burst apart and whether rd_valid stays continuous across burst joins. Requests spaced by random idle gaps show that launch follows arrival and that rd_valid drops for the right number of clocks between bursts. Auto-precharge reads placed right after an activation pulse separate the row-age hold from the spacing rule, and a plain read to a fresh row shows that the hold is limited to auto precharge. While that hold is active, the queue fills to its limit so that back-pressure and loss can be observed. Runs under two latency and burst settings, plus one where the configuration inputs change after reset, show that timing follows only the captured values.

// File: rtl/gri_pkg.sv
package gri_pkg;

    localparam int BANK_W = 2;
    localparam int COL_W  = 9;
    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        ST_READY    = 2'd0,
        ST_GAP      = 2'd1,
        ST_RAS_WAIT = 2'd2
    } rd_state_e;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic              ap;
    } rd_req_t;

endpackage

// File: rtl/gri_req_fifo.sv
module gri_req_fifo
    import gri_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push,
    input  rd_req_t push_data,
    input  logic    pop,
    output rd_req_t head,
    output logic    empty,
    output logic    full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rd_req_t            slots [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic [CNT_W-1:0]   level;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= step(wr_ptr);
            if (pop)  rd_ptr <= step(rd_ptr);
            if (push && !pop)      level <= level + 1'b1;
            else if (pop && !push) level <= level - 1'b1;
        end
    end

    assign head  = slots[rd_ptr];
    assign empty = (level == '0);
    assign full  = (level == CNT_W'(DEPTH));

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty); // R9
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n) level <= CNT_W'(DEPTH)); // R9

endmodule

// File: rtl/gri_ras_tracker.sv
module gri_ras_tracker #(
    parameter int NBANK    = 4,
    parameter int TRAS_MIN = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBANK-1:0] act_stb,
    input  logic [2:0]       bl_clks,
    output logic [NBANK-1:0] ras_ok
);

    localparam int AGE_W = $clog2(TRAS_MIN + 1);
    localparam int SUM_W = AGE_W + 3;

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [AGE_W-1:0] age;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age <= AGE_W'(TRAS_MIN);
            end else if (act_stb[g]) begin
                age <= '0;
            end else if (age < AGE_W'(TRAS_MIN)) begin
                age <= age + 1'b1;
            end
        end

        // the command register adds one clock, the burst adds bl_clks more
        assign ras_ok[g] = (SUM_W'(age) + SUM_W'(bl_clks) + SUM_W'(2)) >= SUM_W'(TRAS_MIN);

        AST_AGE_SAT: assert property (@(posedge clk) disable iff (!rst_n) age <= AGE_W'(TRAS_MIN)); // R7
    end

endmodule

// File: rtl/gri_valid_pipe.sv
module gri_valid_pipe #(
    parameter int CL_MAX = 12,
    parameter int CL_W   = $clog2(CL_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_seen,
    input  logic [CL_W-1:0] cl_sel,
    input  logic [2:0]      bl_clks,
    output logic            rd_valid
);

    logic [CL_MAX-1:0] delay_sr;
    logic [CL_W-1:0]   tap_idx;
    logic              tap;
    logic [2:0]        burst_left;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_sr <= '0;
        end else begin
            delay_sr <= {delay_sr[CL_MAX-2:0], cmd_seen};
        end
    end

    assign tap_idx = cl_sel - 1'b1;
    assign tap     = delay_sr[tap_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            burst_left <= '0;
        end else if (tap) begin
            burst_left <= bl_clks - 3'd1;
        end else if (burst_left != '0) begin
            burst_left <= burst_left - 3'd1;
        end
    end

    assign rd_valid = tap | (burst_left != '0);

    AST_NO_TRUNCATE: assert property (@(posedge clk) disable iff (!rst_n) tap |-> (burst_left == '0)); // R6

endmodule

// File: rtl/gddr_rd_issuer.sv
module gddr_rd_issuer
    import gri_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int NBANK      = 4,
    parameter int TRAS_MIN   = 14,
    parameter int CL_MAX     = 12,
    localparam int CL_W      = $clog2(CL_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CL_W-1:0]   cfg_cas_lat,
    input  logic              cfg_bl8,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_ap,
    input  logic [NBANK-1:0]  act_bank_stb,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] ba,
    output logic              rd_valid
);

    // captured configuration
    logic [CL_W-1:0] cl_q;
    logic            bl8_q;
    logic [2:0]      bl_clks;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cl_q  <= cfg_cas_lat;
            bl8_q <= cfg_bl8;
        end
    end

    assign bl_clks = bl8_q ? 3'd4 : 3'd2;

    // request queue
    rd_req_t in_req;
    rd_req_t head;
    logic    q_empty;
    logic    q_full;
    logic    fire;

    assign in_req    = '{bank: req_bank, col: req_col, ap: req_ap};
    assign req_ready = !q_full;

    gri_req_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (req_valid && !q_full),
        .push_data (in_req),
        .pop       (fire),
        .head      (head),
        .empty     (q_empty),
        .full      (q_full)
    );

    // row age per bank
    logic [NBANK-1:0] ras_ok;

    gri_ras_tracker #(.NBANK(NBANK), .TRAS_MIN(TRAS_MIN)) u_ras (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_stb (act_bank_stb),
        .bl_clks (bl_clks),
        .ras_ok  (ras_ok)
    );

    // state machine
    rd_state_e  state;
    rd_state_e  state_nx;
    logic [2:0] gap_cnt;
    logic       head_vld;
    logic       ras_hold;
    logic       can_fire;

    assign head_vld = !q_empty;
    assign ras_hold = head.ap && !ras_ok[head.bank];
    assign can_fire = head_vld && !ras_hold;
    assign fire     = (state != ST_GAP) && can_fire;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_READY: begin
                if (can_fire)                 state_nx = ST_GAP;
                else if (head_vld && ras_hold) state_nx = ST_RAS_WAIT;
            end
            ST_RAS_WAIT: begin
                if (can_fire) state_nx = ST_GAP;
            end
            ST_GAP: begin
                if (gap_cnt == 3'd1) state_nx = ST_READY;
            end
            default: state_nx = ST_READY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_READY;
            gap_cnt <= '0;
        end else begin
            state <= state_nx;
            if (fire)                 gap_cnt <= bl_clks - 3'd1;
            else if (gap_cnt != '0)   gap_cnt <= gap_cnt - 3'd1;
        end
    end

    // command pins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n  <= 1'b1;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            addr  <= '0;
            ba    <= '0;
        end else if (fire) begin
            cs_n  <= 1'b0;
            ras_n <= 1'b1;
            cas_n <= 1'b0;
            we_n  <= 1'b1;
            ba    <= head.bank;
            addr  <= {2'b00, head.col[8], head.ap, head.col[7:0]};
        end else begin
            cs_n  <= 1'b1;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            addr  <= '0;
            ba    <= '0;
        end
    end

    // data-valid prediction
    gri_valid_pipe #(.CL_MAX(CL_MAX), .CL_W(CL_W)) u_vld (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_seen (!cs_n),
        .cl_sel   (cl_q),
        .bl_clks  (bl_clks),
        .rd_valid (rd_valid)
    );

    // distance between READs on the pins, saturating
    logic [2:0] since_rd;

    always_ff @(posedge clk) begin
        if (!rst_n)              since_rd <= 3'd7;
        else if (!cs_n)          since_rd <= 3'd1;
        else if (since_rd != 3'd7) since_rd <= since_rd + 3'd1;
    end

    AST_CMD_ENCODING: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> (ras_n && !cas_n && we_n)); // R1
    AST_HIGH_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> (addr[11:10] == 2'b00)); // R2
    AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> (since_rd >= bl_clks)); // R5
    AST_CL_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (cl_q >= CL_W'(1)) && (cl_q <= CL_W'(CL_MAX))); // R8

endmodule

// File: tb/gddr_rd_issuer_tb.sv
module gddr_rd_issuer_tb_top;

    localparam int TRAS = 14;
    localparam int NCYC = 60000;
    localparam int NEXP = 2048;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cfg_cas_lat = 4'd5;
    logic       cfg_bl8 = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_bank = '0;
    logic [8:0] req_col = '0;
    logic       req_ap = 1'b0;
    logic [3:0] act_bank_stb = '0;
    logic       cs_n, ras_n, cas_n, we_n;
    logic [11:0] addr;
    logic [1:0] ba;
    logic       rd_valid;

    gddr_rd_issuer #(.TRAS_MIN(TRAS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_cas_lat(cfg_cas_lat), .cfg_bl8(cfg_bl8),
        .req_valid(req_valid), .req_ready(req_ready), .req_bank(req_bank),
        .req_col(req_col), .req_ap(req_ap), .act_bank_stb(act_bank_stb),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba), .rd_valid(rd_valid)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_err = 0;
    string cur_tag = "R3";

    // reference model state
    int m_cl, m_bl, prev_cmd, n_exp, mon_idx;
    int last_act [4];
    int exp_cyc [NEXP];
    logic [1:0] exp_bank [NEXP];
    logic [11:0] exp_addr [NEXP];
    bit exp_vld [NCYC];
    bit mon_en = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, expv);
        end
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [11:0] addr_of(input logic [8:0] col, input logic ap);
        return {2'b00, col[8], ap, col[7:0]};
    endfunction

    task automatic model_clear();
        prev_cmd = -1000;
        n_exp = 0;
        mon_idx = 0;
        foreach (last_act[i]) last_act[i] = -100000;
        foreach (exp_vld[i]) exp_vld[i] = 1'b0;
    endtask

    // earliest launch clock from arrival, spacing and row age
    task automatic model_push(input int acc, input logic [1:0] b, input logic [8:0] c, input logic ap);
        int t;
        t = imax(acc + 2, prev_cmd + m_bl);
        if (ap) t = imax(t, last_act[b] + TRAS - m_bl);
        prev_cmd = t;
        exp_cyc[n_exp] = t;
        exp_bank[n_exp] = b;
        exp_addr[n_exp] = addr_of(c, ap);
        n_exp++;
        for (int k = 0; k < m_bl; k++) exp_vld[t + m_cl + k] = 1'b1;
    endtask

    // called at a falling edge; returns at the falling edge after acceptance
    task automatic send(input logic [1:0] b, input logic [8:0] c, input logic ap);
        req_valid = 1'b1;
        req_bank = b;
        req_col = c;
        req_ap = ap;
        while (!req_ready) @(negedge clk);
        model_push(cyc, b, c, ap);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic activate(input int b);
        act_bank_stb = 4'(1 << b);
        last_act[b] = cyc;
        @(negedge clk);
        act_bank_stb = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input int cl, input bit bl8);
        mon_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_cas_lat = 4'(cl);
        cfg_bl8 = bl8;
        idle(3);
        m_cl = cl;
        m_bl = bl8 ? 4 : 2;
        model_clear();
        rst_n = 1'b1;
        mon_en = 1'b1;
        chk(cs_n === 1'b1 && ras_n === 1'b1 && cas_n === 1'b1 && we_n === 1'b1, "R1", "reset pins idle", cs_n, 1);
        chk(rd_valid === 1'b0, "R4", "reset rd_valid", rd_valid, 0);
        chk(req_ready === 1'b1, "R9", "reset req_ready", req_ready, 1);
    endtask

    task automatic drain(input string tag);
        idle(40);
        chk(mon_idx == n_exp, tag, "READs launched", mon_idx, n_exp);
    endtask

    // per-clock monitor of pins and strobe
    always @(negedge clk) begin
        if (mon_en) begin
            if (mon_idx < n_exp && exp_cyc[mon_idx] < cyc) begin
                chk(1'b0, cur_tag, "READ missing", cyc, exp_cyc[mon_idx]);
                mon_idx++;
            end
            if (mon_idx < n_exp && exp_cyc[mon_idx] == cyc) begin
                chk(cs_n === 1'b0 && ras_n === 1'b1 && cas_n === 1'b0 && we_n === 1'b1,
                    "R1", "READ encoding", {cs_n, ras_n, cas_n, we_n}, 4'b0101);
                chk(addr === exp_addr[mon_idx], "R2", "READ addr", addr, exp_addr[mon_idx]);
                chk(ba === exp_bank[mon_idx], "R2", "READ bank", ba, exp_bank[mon_idx]);
                mon_idx++;
            end else begin
                chk(cs_n === 1'b1 && ras_n === 1'b1 && cas_n === 1'b1 && we_n === 1'b1 && addr === '0 && ba === '0,
                    cur_tag, "deselect expected", cs_n, 1);
            end
            if (cyc < NCYC)
                chk(rd_valid === exp_vld[cyc], "R4", "rd_valid", rd_valid, exp_vld[cyc]);
        end
    end

    initial begin : watchdog
        wait (cyc > 100000);
        chk(1'b0, "R3", "watchdog expired", cyc, 100000);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20251));

        // setting A: CL=5, BL=4
        do_reset(5, 1'b0);
        cur_tag = "R5";
        for (int i = 0; i < 8; i++) send(2'(i), 9'(i * 37 + 256), 1'(i & 1));
        drain("R5");

        cur_tag = "R3";
        for (int i = 0; i < 60; i++) begin
            send(2'($urandom_range(0, 3)), 9'($urandom_range(0, 511)), 1'($urandom_range(0, 1)));
            idle($urandom_range(0, 5));
        end
        drain("R3");

        // configuration inputs move after reset
        cur_tag = "R8";
        cfg_cas_lat = 4'd9;
        cfg_bl8 = 1'b1;
        for (int i = 0; i < 40; i++) begin
            send(2'($urandom_range(0, 3)), 9'($urandom_range(0, 511)), 1'b0);
            idle($urandom_range(0, 2));
        end
        drain("R8");

        // row-age hold, then a plain read to a fresh row
        cur_tag = "R7";
        activate(1);
        send(2'd1, 9'h1A5, 1'b1);
        drain("R7");
        activate(2);
        send(2'd2, 9'h0F0, 1'b0);
        drain("R7");
        activate(3);
        idle(5);
        send(2'd3, 9'h111, 1'b1);
        drain("R7");

        // fill the queue behind a held request
        cur_tag = "R9";
        activate(0);
        send(2'd0, 9'h001, 1'b1);
        send(2'd1, 9'h002, 1'b0);
        send(2'd2, 9'h003, 1'b0);
        send(2'd3, 9'h004, 1'b1);
        chk(req_ready === 1'b0, "R9", "req_ready with full queue", req_ready, 0);
        send(2'd1, 9'h005, 1'b0);
        drain("R9");

        // setting B: CL=7, BL=8
        do_reset(7, 1'b1);
        cur_tag = "R6";
        for (int i = 0; i < 120; i++) begin
            send(2'($urandom_range(0, 3)), 9'($urandom_range(0, 511)), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 9));
        end
        drain("R6");
        cur_tag = "R7";
        activate(2);
        send(2'd2, 9'h155, 1'b1);
        send(2'd2, 9'h0AA, 1'b0);
        drain("R7");

        // setting C: largest latency
        do_reset(12, 1'b0);
        cur_tag = "R4";
        for (int i = 0; i < 30; i++) begin
            send(2'($urandom_range(0, 3)), 9'($urandom_range(0, 511)), 1'($urandom_range(0, 1)));
            idle($urandom_range(0, 3));
        end
        drain("R4");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule